// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the software-visible register file that sits in front of an eight-ring Ethernet DMA controller. A host issues 32-bit reads and writes into a 4 KB window; the word index is the byte address shifted right by two. Every location has one of four access policies: read-write, write-only (reads return zero), write-one-to-clear, or read-only. Locations that are not defined read zero and ignore writes.

Beyond plain storage, a few registers have side effects. The event register collects interrupt causes, set by hardware strobes and cleared by software. It drives three interrupt lines (transmit, receive, error) through a mask register. Two halt-status registers hold one flag per transmit ring and per receive ring. Writing a 1 to a halt flag clears it and sends a one-cycle restart pulse to the DMA engine for that ring. The receive side pulses only when the flag was already clear. Writing a ring base register aligns the value to 8 bytes and also reloads that ring's current-descriptor pointer.

Top module: `dma_csr_bank`

## Requirements
- R1: The word index is `bus_addr_i[11:2]`; the two low address bits are ignored. Read data appears on `bus_rdata_o` in the cycle after a read request (`bus_sel_i`=1, `bus_wr_i`=0) and holds until the next read.
- R2: After reset the registers hold these values: event 0, mask 0, control 0x000000C0, command 0, ID 0x01020300, transmit halt 0xFF000000, receive halt 0x00FF0000, every base and pointer 0. All three interrupt lines and all restart pulses are low.
- R3: These read-write registers store the written word and read it back: mask (0x004), control (0x008, also on `ctrl_word_o`) and ring pointers (transmit ring i at 0x120+4i, receive ring i at 0x160+4i). The command register (0x00C) is write-only: it stores the word and drives it on `cmd_word_o`, and reads of it return 0.
- R4: The ID register (0x010) is read-only and ignores writes. Undefined locations (for example 0x01C and 0x3FC) read 0 and ignore writes.
- R5: The event register (0x000) is write-one-to-clear. A bit of `evt_set_i` sets the matching event bit. This wins over a software clear of the same bit in the same cycle.
- R6: An interrupt line goes high in the cycle after an `evt_set_i` strobe on one of its bits while the matching mask bit is 1. Event bit 0 feeds `irq_tx_o`, bit 1 feeds `irq_rx_o`, and bits 31..2 feed `irq_err_o`. A strobe on a masked-off bit raises no line.
- R7: An interrupt line goes low only in the cycle after a write to the event register that leaves none of its bits set. A write to the mask does not lower a line.
- R8: In the transmit halt register (0x014), bit 31-i belongs to transmit ring i. Writing 1 there clears the bit and raises `tx_kick_o[i]` for exactly the next cycle, whatever the stored value was.
- R9: In the receive halt register (0x018), bit 23-i belongs to receive ring i. Written 1-bits are cleared. `rx_kick_o[i]` pulses for one cycle only if that bit was 0 before the write.
- R10: `tx_halt_set_i[i]` and `rx_halt_set_i[i]` set the halt flag of ring i. A set wins over a same-cycle software clear, and the restart pulse is still issued.
- R11: A write to transmit base i (0x100+4i) or receive base i (0x140+4i) stores the value with bits 2..0 forced to 0. The same aligned value is loaded into that ring's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| evt_set_i | input | 32 | Hardware event set strobes |
| tx_halt_set_i | input | 8 | Hardware transmit-ring halt strobes |
| rx_halt_set_i | input | 8 | Hardware receive-ring halt strobes |
| tx_kick_o | output | 8 | Transmit ring restart pulses |
| rx_kick_o | output | 8 | Receive ring restart pulses |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Error interrupt |
| ctrl_word_o | output | 32 | Current control register |
| cmd_word_o | output | 32 | Current command register |

## Verification
A corrupt halt flag shows up first at the restart outputs. A wrong receive flag suppresses or adds an `rx_kick_o` pulse in the cycle right after the next write of 1 to that ring. A readback then exposes the stored value one cycle later. An event bit held wrongly shows on an interrupt line only at the next event-register write, when the line fails to fall, or at the next masked strobe. The bench therefore samples the interrupt lines right after every strobe and every clear. A mis-loaded ring pointer stays silent until it is read, so each base write is followed by a read of the matching pointer.

// File: rtl/dcsr_pkg.sv
// Shared definitions for the DMA control/status register bank.
// Assumes at most eight rings per direction (halt flag layout is fixed).
package dcsr_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_EVT, K_MASK, K_CTRL, K_CMD, K_ID,
        K_TXH, K_RXH, K_TXB, K_TXP, K_RXB, K_RXP
    } reg_kind_e;

    localparam int unsigned IDX_EVT  = 0;
    localparam int unsigned IDX_MASK = 1;
    localparam int unsigned IDX_CTRL = 2;
    localparam int unsigned IDX_CMD  = 3;
    localparam int unsigned IDX_ID   = 4;
    localparam int unsigned IDX_TXH  = 5;
    localparam int unsigned IDX_RXH  = 6;
    localparam int unsigned IDX_TXB  = 64;
    localparam int unsigned IDX_TXP  = 72;
    localparam int unsigned IDX_RXB  = 80;
    localparam int unsigned IDX_RXP  = 88;

    localparam int unsigned EVT_TXF = 0;
    localparam int unsigned EVT_RXF = 1;
    localparam logic [31:0] ERR_GROUP = 32'hFFFF_FFFC;

    localparam int unsigned TXH_TOP = 31;
    localparam int unsigned RXH_TOP = 23;

    // Mask of halt flag bits for n rings starting at bit 'top' going down
    function automatic logic [31:0] halt_field(input int unsigned n, input int unsigned top);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < n; i++) begin
            m[top - i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dcsr_decode.sv
// Address decoder: maps a byte address to a register kind and ring number.
// Assumes 32-bit accesses only; the two low address bits are dropped.
module dcsr_decode
    import dcsr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_RINGS = 8,
    parameter int unsigned RING_W    = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [RING_W-1:0] ring_o
);
    logic [ADDR_W-3:0] word;
    int unsigned       widx;
    logic [1:0]        unused_lo_bits;

    assign word           = addr_i[ADDR_W-1:2];
    assign unused_lo_bits = addr_i[1:0];
    assign widx           = 32'(word);
    assign ring_o         = word[RING_W-1:0];

    // Classify the word index into one register kind
    always_comb begin
        kind_o = K_NONE;
        if (widx == IDX_EVT)       kind_o = K_EVT;
        else if (widx == IDX_MASK) kind_o = K_MASK;
        else if (widx == IDX_CTRL) kind_o = K_CTRL;
        else if (widx == IDX_CMD)  kind_o = K_CMD;
        else if (widx == IDX_ID)   kind_o = K_ID;
        else if (widx == IDX_TXH)  kind_o = K_TXH;
        else if (widx == IDX_RXH)  kind_o = K_RXH;
        else if (widx >= IDX_TXB && widx < IDX_TXB + NUM_RINGS) kind_o = K_TXB;
        else if (widx >= IDX_TXP && widx < IDX_TXP + NUM_RINGS) kind_o = K_TXP;
        else if (widx >= IDX_RXB && widx < IDX_RXB + NUM_RINGS) kind_o = K_RXB;
        else if (widx >= IDX_RXP && widx < IDX_RXP + NUM_RINGS) kind_o = K_RXP;
    end
endmodule

// File: rtl/dcsr_events.sv
// Event, mask and interrupt line logic.
// Assumes write strobes are one cycle wide; set strobes beat software clears.
module dcsr_events
    import dcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_evt_i,
    input  logic        wr_mask_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] evt_set_i,
    output logic [31:0] evt_q,
    output logic [31:0] mask_q,
    output logic        irq_tx_o,
    output logic        irq_rx_o,
    output logic        irq_err_o
);
    logic [31:0] evt_nxt;
    logic [31:0] set_hit;

    // Next event value: clear written ones, then apply hardware sets
    always_comb begin
        evt_nxt = wr_evt_i ? (evt_q & ~wdata_i) : evt_q;
        evt_nxt = evt_nxt | evt_set_i;
        set_hit = evt_set_i & mask_q;
    end

    // Event and mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            mask_q <= '0;
        end else begin
            evt_q <= evt_nxt;
            if (wr_mask_i) mask_q <= wdata_i;
        end
    end

    // Interrupt lines: raise on masked set, drop after a clearing event write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx_o  <= 1'b0;
            irq_rx_o  <= 1'b0;
            irq_err_o <= 1'b0;
        end else begin
            if (set_hit[EVT_TXF])                       irq_tx_o <= 1'b1;
            else if (wr_evt_i && !evt_nxt[EVT_TXF])     irq_tx_o <= 1'b0;
            if (set_hit[EVT_RXF])                       irq_rx_o <= 1'b1;
            else if (wr_evt_i && !evt_nxt[EVT_RXF])     irq_rx_o <= 1'b0;
            if (|(set_hit & ERR_GROUP))                 irq_err_o <= 1'b1;
            else if (wr_evt_i && !(|(evt_nxt & ERR_GROUP))) irq_err_o <= 1'b0;
        end
    end

    // R7
    irq_tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_tx_o) |-> $past(wr_evt_i))
        else $error("irq_tx fell without an event write");

    // R7
    irq_err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_err_o) |-> $past(wr_evt_i) && !(|(evt_q & ERR_GROUP)))
        else $error("irq_err fell while error events remain");

    // R6
    irq_tx_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_set_i[EVT_TXF] && mask_q[EVT_TXF]) |-> irq_tx_o)
        else $error("masked transmit event did not raise irq_tx");

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q & $past(evt_set_i)) == $past(evt_set_i))
        else $error("event set strobe lost");
endmodule

// File: rtl/dcsr_halt.sv
// Per-ring transmit and receive halt flags with restart pulse generation.
// Assumes flag i of transmit sits at bit 31-i and of receive at bit 23-i.
module dcsr_halt
    import dcsr_pkg::*;
#(
    parameter int unsigned NUM_RINGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_tx_i,
    input  logic                 wr_rx_i,
    input  logic [31:0]          wdata_i,
    input  logic [NUM_RINGS-1:0] tx_set_i,
    input  logic [NUM_RINGS-1:0] rx_set_i,
    output logic [31:0]          tx_q,
    output logic [31:0]          rx_q,
    output logic [NUM_RINGS-1:0] tx_kick_o,
    output logic [NUM_RINGS-1:0] rx_kick_o
);
    localparam logic [31:0] TX_FIELD = halt_field(NUM_RINGS, TXH_TOP);
    localparam logic [31:0] RX_FIELD = halt_field(NUM_RINGS, RXH_TOP);

    logic [31:0]          tx_clr, rx_clr, tx_setv, rx_setv;
    logic [NUM_RINGS-1:0] tx_kick_nxt, rx_kick_nxt;

    genvar g;
    generate
        for (g = 0; g < NUM_RINGS; g++) begin : g_ring
            // Map per-ring strobes and decide restart pulses for ring g
            always_comb begin
                tx_kick_nxt[g] = wr_tx_i && wdata_i[TXH_TOP - g];
                rx_kick_nxt[g] = wr_rx_i && wdata_i[RXH_TOP - g] && !rx_q[RXH_TOP - g];
            end

            // R9
            rx_kick_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rx_kick_o[g] |-> $past(wr_rx_i) && !$past(rx_q[RXH_TOP - g]))
                else $error("receive restart pulse while flag was set");

            // R8
            tx_kick_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tx_kick_o[g] |-> $past(wr_tx_i) && !tx_q[TXH_TOP - g] || $past(tx_set_i[g]))
                else $error("transmit restart pulse without clearing write");
        end
    endgenerate

    // Expand per-ring set strobes into register bit positions
    always_comb begin
        tx_setv = '0;
        rx_setv = '0;
        for (int unsigned i = 0; i < NUM_RINGS; i++) begin
            tx_setv[TXH_TOP - i] = tx_set_i[i];
            rx_setv[RXH_TOP - i] = rx_set_i[i];
        end
        tx_clr = wr_tx_i ? wdata_i : '0;
        rx_clr = wr_rx_i ? wdata_i : '0;
    end

    // Flag storage and registered restart pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= TX_FIELD;
            rx_q      <= RX_FIELD;
            tx_kick_o <= '0;
            rx_kick_o <= '0;
        end else begin
            tx_q      <= ((tx_q & ~tx_clr) | tx_setv) & TX_FIELD;
            rx_q      <= ((rx_q & ~rx_clr) | rx_setv) & RX_FIELD;
            tx_kick_o <= tx_kick_nxt;
            rx_kick_o <= rx_kick_nxt;
        end
    end
endmodule

// File: rtl/dcsr_rings.sv
// Base and current-pointer registers for one direction of the rings.
// Assumes at most one of the write enables is high in a cycle.
module dcsr_rings #(
    parameter int unsigned NUM_RINGS = 8,
    parameter int unsigned RING_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_base_i,
    input  logic                       wr_ptr_i,
    input  logic [RING_W-1:0]          ring_i,
    input  logic [31:0]                wdata_i,
    output logic [NUM_RINGS-1:0][31:0] base_q,
    output logic [NUM_RINGS-1:0][31:0] ptr_q
);
    logic [31:0] aligned;

    assign aligned = {wdata_i[31:3], 3'b000};

    genvar g;
    generate
        for (g = 0; g < NUM_RINGS; g++) begin : g_ring
            // Base write aligns and reloads pointer; pointer write stores as is
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q[g] <= '0;
                    ptr_q[g]  <= '0;
                end else if (32'(ring_i) == g) begin
                    if (wr_base_i) begin
                        base_q[g] <= aligned;
                        ptr_q[g]  <= aligned;
                    end else if (wr_ptr_i) begin
                        ptr_q[g]  <= wdata_i;
                    end
                end
            end
        end
    endgenerate

    // R11
    base_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_base_i) |-> ptr_q[$past(ring_i)] == base_q[$past(ring_i)]
                             && base_q[$past(ring_i)][2:0] == 3'b000)
        else $error("ring pointer not reloaded from aligned base");
endmodule

// File: rtl/dma_csr_bank.sv
// Top of the DMA control/status register bank: decode, write steering,
// plain registers and registered read mux.
// Assumes single-cycle 32-bit bus accesses with no wait states.
module dma_csr_bank
    import dcsr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_RINGS = 8,
    parameter logic [31:0] CTRL_RST  = 32'h0000_00C0,
    parameter logic [31:0] ID_VALUE  = 32'h0102_0300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    input  logic [31:0]          evt_set_i,
    input  logic [NUM_RINGS-1:0] tx_halt_set_i,
    input  logic [NUM_RINGS-1:0] rx_halt_set_i,
    output logic [NUM_RINGS-1:0] tx_kick_o,
    output logic [NUM_RINGS-1:0] rx_kick_o,
    output logic                 irq_tx_o,
    output logic                 irq_rx_o,
    output logic                 irq_err_o,
    output logic [31:0]          ctrl_word_o,
    output logic [31:0]          cmd_word_o
);
    localparam int unsigned RING_W = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;

    reg_kind_e   kind;
    logic [RING_W-1:0] ring;
    logic        wr_en, rd_en;
    logic [31:0] evt_q, mask_q, txh_q, rxh_q, ctrl_q, cmd_q, rd_mux;
    logic [NUM_RINGS-1:0][31:0] txb_q, txp_q, rxb_q, rxp_q;

    assign wr_en       = bus_sel_i && bus_wr_i;
    assign rd_en       = bus_sel_i && !bus_wr_i;
    assign ctrl_word_o = ctrl_q;
    assign cmd_word_o  = cmd_q;

    dcsr_decode #(.ADDR_W(ADDR_W), .NUM_RINGS(NUM_RINGS), .RING_W(RING_W)) decode_i (
        .addr_i (bus_addr_i),
        .kind_o (kind),
        .ring_o (ring)
    );

    dcsr_events events_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt_i  (wr_en && kind == K_EVT),
        .wr_mask_i (wr_en && kind == K_MASK),
        .wdata_i   (bus_wdata_i),
        .evt_set_i (evt_set_i),
        .evt_q     (evt_q),
        .mask_q    (mask_q),
        .irq_tx_o  (irq_tx_o),
        .irq_rx_o  (irq_rx_o),
        .irq_err_o (irq_err_o)
    );

    dcsr_halt #(.NUM_RINGS(NUM_RINGS)) halt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_tx_i   (wr_en && kind == K_TXH),
        .wr_rx_i   (wr_en && kind == K_RXH),
        .wdata_i   (bus_wdata_i),
        .tx_set_i  (tx_halt_set_i),
        .rx_set_i  (rx_halt_set_i),
        .tx_q      (txh_q),
        .rx_q      (rxh_q),
        .tx_kick_o (tx_kick_o),
        .rx_kick_o (rx_kick_o)
    );

    dcsr_rings #(.NUM_RINGS(NUM_RINGS), .RING_W(RING_W)) tx_rings_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_base_i (wr_en && kind == K_TXB),
        .wr_ptr_i  (wr_en && kind == K_TXP),
        .ring_i    (ring),
        .wdata_i   (bus_wdata_i),
        .base_q    (txb_q),
        .ptr_q     (txp_q)
    );

    dcsr_rings #(.NUM_RINGS(NUM_RINGS), .RING_W(RING_W)) rx_rings_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_base_i (wr_en && kind == K_RXB),
        .wr_ptr_i  (wr_en && kind == K_RXP),
        .ring_i    (ring),
        .wdata_i   (bus_wdata_i),
        .base_q    (rxb_q),
        .ptr_q     (rxp_q)
    );

    // Plain read-write control and write-only command storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            cmd_q  <= '0;
        end else if (wr_en) begin
            if (kind == K_CTRL) ctrl_q <= bus_wdata_i;
            if (kind == K_CMD)  cmd_q  <= bus_wdata_i;
        end
    end

    // Select read value by access policy; write-only and unknown read zero
    always_comb begin
        unique case (kind)
            K_EVT:   rd_mux = evt_q;
            K_MASK:  rd_mux = mask_q;
            K_CTRL:  rd_mux = ctrl_q;
            K_ID:    rd_mux = ID_VALUE;
            K_TXH:   rd_mux = txh_q;
            K_RXH:   rd_mux = rxh_q;
            K_TXB:   rd_mux = txb_q[ring];
            K_TXP:   rd_mux = txp_q[ring];
            K_RXB:   rd_mux = rxb_q[ring];
            K_RXP:   rd_mux = rxp_q[ring];
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, updated only on a read request
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata_o <= '0;
        else if (rd_en) bus_rdata_o <= rd_mux;
    end

    // R3
    wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && kind == K_CMD) |-> bus_rdata_o == 32'h0)
        else $error("write-only register read back nonzero");

    // R4
    unknown_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && kind == K_NONE) |-> bus_rdata_o == 32'h0)
        else $error("undefined location read back nonzero");

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) && $past(rst_n) |-> $stable(bus_rdata_o))
        else $error("read data changed without a read");
endmodule

// File: tb/dma_csr_bank_tb.sv
// Self-checking bench for the DMA control/status register bank.
module dma_csr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, evt_set = '0;
    logic [7:0]  tx_set = '0, rx_set = '0;
    logic [31:0] bus_rdata, ctrl_word, cmd_word;
    logic [7:0]  tx_kick, rx_kick;
    logic        irq_tx, irq_rx, irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_csr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .evt_set_i(evt_set), .tx_halt_set_i(tx_set), .rx_halt_set_i(rx_set),
        .tx_kick_o(tx_kick), .rx_kick_o(rx_kick), .irq_tx_o(irq_tx),
        .irq_rx_o(irq_rx), .irq_err_o(irq_err), .ctrl_word_o(ctrl_word),
        .cmd_word_o(cmd_word)
    );

    // {req 8, wr 1, addr 12, data 32, expected read 32}
    localparam int NV = 22;
    localparam logic [84:0] VEC [NV] = '{
        {8'd3,  1'b1, 12'h004, 32'hA5A5_0003, 32'h0},           // R3 mask
        {8'd3,  1'b0, 12'h004, 32'h0,         32'hA5A5_0003},
        {8'd3,  1'b1, 12'h008, 32'h1234_5678, 32'h0},           // R3 control
        {8'd3,  1'b0, 12'h008, 32'h0,         32'h1234_5678},
        {8'd3,  1'b1, 12'h00C, 32'hDEAD_BEEF, 32'h0},           // R3 write-only
        {8'd3,  1'b0, 12'h00C, 32'h0,         32'h0},
        {8'd4,  1'b1, 12'h010, 32'h0,         32'h0},           // R4 read-only ID
        {8'd4,  1'b0, 12'h010, 32'h0,         32'h0102_0300},
        {8'd4,  1'b1, 12'h3FC, 32'hFFFF_FFFF, 32'h0},           // R4 unknown
        {8'd4,  1'b0, 12'h3FC, 32'h0,         32'h0},
        {8'd4,  1'b1, 12'h01C, 32'h0000_0001, 32'h0},
        {8'd4,  1'b0, 12'h01C, 32'h0,         32'h0},
        {8'd1,  1'b1, 12'h129, 32'h0000_1007, 32'h0},           // R1 low bits ignored
        {8'd1,  1'b0, 12'h12B, 32'h0,         32'h0000_1007},
        {8'd11, 1'b1, 12'h10C, 32'h0000_2ABF, 32'h0},           // R11 tx base 3
        {8'd11, 1'b0, 12'h10C, 32'h0,         32'h0000_2AB8},
        {8'd11, 1'b0, 12'h12C, 32'h0,         32'h0000_2AB8},
        {8'd11, 1'b1, 12'h15C, 32'hFFFF_FFFF, 32'h0},           // R11 rx base 7
        {8'd11, 1'b0, 12'h15C, 32'h0,         32'hFFFF_FFF8},
        {8'd11, 1'b0, 12'h17C, 32'h0,         32'hFFFF_FFF8},
        {8'd3,  1'b1, 12'h160, 32'h0000_0013, 32'h0},           // R3 rx pointer
        {8'd3,  1'b0, 12'h160, 32'h0,         32'h0000_0013}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus/strobe cycle, starting and ending at a falling edge
    task automatic cyc(input logic sel, input logic wr, input logic [11:0] a,
                       input logic [31:0] d, input logic [31:0] es,
                       input logic [7:0] ts, input logic [7:0] rs);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        evt_set = es; tx_set = ts; rx_set = rs;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0; tx_set = '0; rx_set = '0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, '0, '0, '0);
    endtask

    task automatic rd32(input logic [11:0] a);
        cyc(1'b1, 1'b0, a, '0, '0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 reset state
        chk("R2 irq/kick", {irq_tx, irq_rx, irq_err, tx_kick, rx_kick}, 32'h0);
        chk("R2 ctrl", ctrl_word, 32'h0000_00C0);
        chk("R2 cmd", cmd_word, 32'h0);
        rd32(12'h000); chk("R2 event", bus_rdata, 32'h0);
        rd32(12'h014); chk("R2 tx halt", bus_rdata, 32'hFF00_0000);
        rd32(12'h018); chk("R2 rx halt", bus_rdata, 32'h00FF_0000);
        rd32(12'h104); chk("R2 tx base", bus_rdata, 32'h0);

        // Table walk: writes then readbacks
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) wr32(VEC[i][75:64], VEC[i][63:32]);
            else begin
                rd32(VEC[i][75:64]);
                chk($sformatf("R%0d row %0d", VEC[i][84:77], i), bus_rdata, VEC[i][31:0]);
            end
        end
        chk("R3 cmd output", cmd_word, 32'hDEAD_BEEF);
        chk("R3 ctrl output", ctrl_word, 32'h1234_5678);

        // R6 masked raise
        wr32(12'h004, 32'h0000_0005);
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 32'h0000_0007, '0, '0);
        chk("R6 irq_tx", {31'h0, irq_tx}, 32'h1);
        chk("R6 irq_rx masked", {31'h0, irq_rx}, 32'h0);
        chk("R6 irq_err", {31'h0, irq_err}, 32'h1);
        rd32(12'h000); chk("R5 event set", bus_rdata, 32'h0000_0007);

        // R7 deassert rules
        wr32(12'h004, 32'h0);
        chk("R7 mask write keeps irq_tx", {31'h0, irq_tx}, 32'h1);
        wr32(12'h000, 32'h1);
        chk("R7 irq_tx drop", {31'h0, irq_tx}, 32'h0);
        chk("R7 irq_err held", {31'h0, irq_err}, 32'h1);
        wr32(12'h000, 32'h2);
        chk("R7 irq_err still held", {31'h0, irq_err}, 32'h1);
        wr32(12'h000, 32'h4);
        chk("R7 irq_err drop", {31'h0, irq_err}, 32'h0);
        rd32(12'h000); chk("R5 event cleared", bus_rdata, 32'h0);

        // R5 set beats same-cycle clear; mask off so no line rises
        cyc(1'b1, 1'b1, 12'h000, 32'h8, 32'h8, '0, '0);
        chk("R6 masked err stays low", {31'h0, irq_err}, 32'h0);
        rd32(12'h000); chk("R5 set priority", bus_rdata, 32'h0000_0008);
        wr32(12'h000, 32'h8);
        rd32(12'h000); chk("R5 w1c", bus_rdata, 32'h0);

        // R8 transmit halt
        wr32(12'h014, 32'h8100_0000);
        chk("R8 kick rings 0,7", {24'h0, tx_kick}, 32'h81);
        @(negedge clk);
        chk("R8 kick one cycle", {24'h0, tx_kick}, 32'h0);
        rd32(12'h014); chk("R8 cleared", bus_rdata, 32'h7E00_0000);
        wr32(12'h014, 32'h8000_0000);
        chk("R8 kick when already clear", {24'h0, tx_kick}, 32'h01);

        // R9 receive halt
        wr32(12'h018, 32'h0080_0000);
        chk("R9 no kick while set", {24'h0, rx_kick}, 32'h0);
        rd32(12'h018); chk("R9 cleared", bus_rdata, 32'h007F_0000);
        wr32(12'h018, 32'h0080_0000);
        chk("R9 kick when clear", {24'h0, rx_kick}, 32'h01);
        @(negedge clk);
        chk("R9 kick one cycle", {24'h0, rx_kick}, 32'h0);

        // R10 hardware halt strobes
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 32'h0, 8'h80, 8'h00);
        rd32(12'h014); chk("R10 tx set", bus_rdata, 32'h7F00_0000);
        cyc(1'b1, 1'b1, 12'h014, 32'h0100_0000, 32'h0, 8'h80, 8'h00);
        chk("R10 tx kick with set", {24'h0, tx_kick}, 32'h80);
        rd32(12'h014); chk("R10 tx set wins", bus_rdata, 32'h7F00_0000);
        cyc(1'b1, 1'b1, 12'h018, 32'h0080_0000, 32'h0, 8'h00, 8'h01);
        chk("R10 rx kick with set", {24'h0, rx_kick}, 32'h01);
        rd32(12'h018); chk("R10 rx set wins", bus_rdata, 32'h00FF_0000);

        // R2 reset after activity
        do_reset();
        rd32(12'h014); chk("R2 tx halt after reset", bus_rdata, 32'hFF00_0000);
        rd32(12'h12C); chk("R2 tx pointer after reset", bus_rdata, 32'h0);
        chk("R2 cmd after reset", cmd_word, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule